// File: doc/BRIEF.md
# Accumulator Fractional Divide Controller

This block produces, once per reference clock, the modulus a dual-modulus divider should use so that a fractional-N frequency synthesizer settles at an average division ratio of N plus a binary fraction. It holds an M-bit phase residue and adds the fractional control word to it on every reference cycle. When that sum reaches or passes full scale, a carry is raised. The carry makes the divide output N+1 for that cycle. Otherwise the output is N.

Alongside the divide value, the block exports the carry and the wrapped residue. The residue tracks the phase error that builds up between overflows. A later interpolation or cancellation path can scale it to predict that error and subtract it. The divider, the phase detector and any analog correction sit outside this block.

Top module: `fdc_divctl`

## Requirements
- R1: On each clock edge with `rst_n` high, `phase_res` becomes the previous `phase_res` plus the `frac_word` sampled at that edge, taken modulo 2^FRAC_W.
- R2: `mod_carry` is 1 after an edge exactly when the unwrapped sum of the previous residue and the sampled `frac_word` is at least 2^FRAC_W. Otherwise it is 0.
- R3: `div_out` equals the `n_int` sampled at the same edge when `mod_carry` is 0, and that value plus one when `mod_carry` is 1.
- R4: With FRAC_W=4, `n_int`=4 and `frac_word`=4 (a fraction of 0.25), starting from a cleared residue, `div_out` is 5 on every fourth cycle and 4 on the other three. Over any 2^FRAC_W cycles, the number of carries equals `frac_word`.
- R5: Whenever `mod_carry` is 1, `phase_res` equals the unwrapped sum minus 2^FRAC_W.
- R6: Reset is synchronous and active low. An edge with `rst_n` low clears `phase_res` to 0 and `mod_carry` to 0, and sets `div_out` to the `n_int` sampled at that edge.
- R7: A new `frac_word` or `n_int` is used from the first edge at which it is sampled. Earlier outputs are unaffected.
- R8: While `frac_word` is 0, `mod_carry` stays 0, and `div_out` stays at `n_int` on every cycle.
- R9: `div_out` is INT_W+1 bits wide, so `n_int` = 2^INT_W-1 with a carry gives 2^INT_W without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one accumulation per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| n_int | input | INT_W | Integer part N of the division ratio |
| frac_word | input | FRAC_W | Fractional control word; the fraction is frac_word / 2^FRAC_W |
| div_out | output | INT_W+1 | Modulus for this reference cycle: N or N+1 |
| mod_carry | output | 1 | Accumulator overflow that selects N+1 |
| phase_res | output | FRAC_W | Wrapped residue, proportional to the accumulated phase error |

## Verification
The bench builds the block with FRAC_W=4 and INT_W=4. With these values the whole residue cycle is only 16 states long. The quarter fraction from R4 can then be checked exactly, along with carry counts over a full 2^FRAC_W window and both extremes of the fraction word (0 and 15). INT_W=4 also makes N=15 reachable, so the bench can check the widened divide output at 16, and it can change N and the fraction mid-run to see exactly when the new values take effect.

// File: rtl/fdc_pkg.sv
// Package: shared types for the fractional divide controller.
// Assumes: nothing beyond the standard language.
package fdc_pkg;

    // Which modulus the dual-modulus divider uses in a cycle.
    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } mod_sel_e;

endpackage

// File: rtl/fdc_accum.sv
// Module: fdc_accum
// The first-order phase accumulator. On each clock it adds the fraction
// word to the residue, keeps the residue modulo 2^FRAC_W and registers
// the overflow. It also hands out the next-cycle modulus select, so the
// divide register downstream lines up with the registered carry.
// Assumes: synchronous active-low reset; inputs are stable at the edge.
module fdc_accum
    import fdc_pkg::*;
#(
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [FRAC_W-1:0] residue_o,
    output logic              carry_o,
    output mod_sel_e          sel_nxt_o
);

    localparam int SUM_W = FRAC_W + 1;

    logic [SUM_W-1:0] sum_w;

    // Widened sum: the top bit is the overflow past full scale.
    always_comb begin
        sum_w = {1'b0, residue_o} + {1'b0, frac_i};
    end

    // Map the overflow to a modulus choice for the divide register.
    always_comb begin
        sel_nxt_o = sum_w[SUM_W-1] ? MOD_PLUS1 : MOD_BASE;
    end

    // Residue and carry registers; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            residue_o <= '0;
            carry_o   <= 1'b0;
        end else begin
            residue_o <= sum_w[FRAC_W-1:0];
            carry_o   <= sum_w[SUM_W-1];
        end
    end

endmodule

// File: rtl/fdc_modsel.sv
// Module: fdc_modsel
// The divide-value register. It loads N, or N+1 when the select asks
// for the larger modulus. The output is one bit wider than N, so N+1
// never wraps. Reset forces the plain N.
// Assumes: sel_i is the select for the same edge's accumulation.
module fdc_modsel
    import fdc_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [INT_W-1:0] n_i,
    input  mod_sel_e       sel_i,
    output logic [INT_W:0] div_o
);

    localparam int DIV_W = INT_W + 1;

    logic [DIV_W-1:0] n_wide;
    logic [DIV_W-1:0] n_plus1;

    // Zero-extend N and form N+1 at full output width.
    always_comb begin
        n_wide  = {1'b0, n_i};
        n_plus1 = n_wide + DIV_W'(1);
    end

    // Register the chosen modulus; reset selects N.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_o <= n_wide;
        end else begin
            div_o <= (sel_i == MOD_PLUS1) ? n_plus1 : n_wide;
        end
    end

endmodule

// File: rtl/fdc_divctl.sv
// Module: fdc_divctl (top)
// The per-reference-cycle divide controller for a fractional-N
// synthesizer. It joins the phase accumulator to the divide register
// and exports divide value, carry and residue, all updated on the same edge.
// Assumes: clk is the reference clock; rst_n is synchronous, active low.
module fdc_divctl
    import fdc_pkg::*;
#(
    parameter int FRAC_W = 24,
    parameter int INT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  n_int,
    input  logic [FRAC_W-1:0] frac_word,
    output logic [INT_W:0]    div_out,
    output logic              mod_carry,
    output logic [FRAC_W-1:0] phase_res
);

    mod_sel_e sel_nxt;

    // Phase accumulator: residue, carry and the next modulus select.
    fdc_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .frac_i    (frac_word),
        .residue_o (phase_res),
        .carry_o   (mod_carry),
        .sel_nxt_o (sel_nxt)
    );

    // Divide register: N or N+1.
    fdc_modsel #(.INT_W(INT_W)) u_modsel (
        .clk   (clk),
        .rst_n (rst_n),
        .n_i   (n_int),
        .sel_i (sel_nxt),
        .div_o (div_out)
    );

endmodule

// File: rtl/fdc_divctl_chk.sv
// Module: fdc_divctl_chk
// The assertion checker, bound into fdc_divctl. It checks each output
// against the inputs and outputs of the cycle before.
// Assumes: the first edge after time zero starts the history (past_ok).
module fdc_divctl_chk #(
    parameter int FRAC_W = 24,
    parameter int INT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [INT_W-1:0]  n_int,
    input logic [FRAC_W-1:0] frac_word,
    input logic [INT_W:0]    div_out,
    input logic              mod_carry,
    input logic [FRAC_W-1:0] phase_res
);

    localparam int SUM_W = FRAC_W + 1;
    localparam int DIV_W = INT_W + 1;

    logic past_ok = 1'b0;

    // Marks that at least one edge has been seen, so $past is meaningful.
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
    end

    AST_RESIDUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n)) |->
        ({1'b0, phase_res} == (({1'b0, $past(phase_res)} + {1'b0, $past(frac_word)}) & {1'b0, {FRAC_W{1'b1}}}))); // R1

    AST_CARRY_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n)) |->
        (mod_carry == (({1'b0, $past(phase_res)} + {1'b0, $past(frac_word)}) >= {1'b1, {FRAC_W{1'b0}}}))); // R2

    AST_DIV_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (div_out == ({1'b0, $past(n_int)} + DIV_W'(mod_carry)))); // R3

    AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n) && mod_carry) |->
        ({1'b1, phase_res} == (SUM_W'({1'b0, $past(phase_res)}) + SUM_W'({1'b0, $past(frac_word)})))); // R5

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!past_ok)
        !$past(rst_n) |->
        (phase_res == '0 && !mod_carry && div_out == {1'b0, $past(n_int)})); // R6

    AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(frac_word) == '0) |-> !mod_carry); // R8

endmodule

bind fdc_divctl fdc_divctl_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .n_int     (n_int),
    .frac_word (frac_word),
    .div_out   (div_out),
    .mod_carry (mod_carry),
    .phase_res (phase_res)
);

// File: tb/fdc_divctl_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios for fdc_divctl with FRAC_W=4, INT_W=4.
module fdc_divctl_test;

    localparam int FW = 4;
    localparam int IW = 4;
    localparam int FULL = 1 << FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] n_int = '0;
    logic [FW-1:0] frac_word = '0;
    logic [IW:0]   div_out;
    logic          mod_carry;
    logic [FW-1:0] phase_res;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state, derived from the requirements.
    int m_res = 0;
    int m_carry = 0;
    int m_div = 0;

    fdc_divctl #(.FRAC_W(FW), .INT_W(IW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_int     (n_int),
        .frac_word (frac_word),
        .div_out   (div_out),
        .mod_carry (mod_carry),
        .phase_res (phase_res)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One reference cycle: drive, clock, update model, sample 1 ns after edge.
    task automatic step(input bit rn, input int n, input int f);
        int sum;
        rst_n = rn;
        n_int = IW'(n);
        frac_word = FW'(f);
        @(posedge clk);
        if (!rn) begin
            m_res = 0; m_carry = 0; m_div = n;
        end else begin
            sum = m_res + f;
            m_carry = (sum >= FULL) ? 1 : 0;
            m_res = sum % FULL;
            m_div = n + m_carry;
        end
        #1;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " residue"}, int'(phase_res), m_res);
        chk({tag, " carry"}, int'(mod_carry), m_carry);
        chk({tag, " divide"}, int'(div_out), m_div);
    endtask

    task automatic t_reset();
        step(1'b0, 7, 9);
        chk("R6 reset residue", int'(phase_res), 0);
        chk("R6 reset carry", int'(mod_carry), 0);
        chk("R6 reset divide forced to N", int'(div_out), 7);
    endtask

    task automatic t_quarter();
        int fives = 0;
        step(1'b0, 4, 4);
        for (int i = 1; i <= 16; i++) begin
            step(1'b1, 4, 4);
            chk("R4 quarter pattern", int'(div_out), (i % 4 == 0) ? 5 : 4);
            if (div_out == 5) fives++;
        end
        chk("R4 carries per 16 cycles", fives, 4);
    endtask

    task automatic t_zero();
        step(1'b0, 9, 0);
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 9, 0);
            chk("R8 zero fraction carry", int'(mod_carry), 0);
            chk("R8 zero fraction divide", int'(div_out), 9);
        end
    endtask

    task automatic t_sweep();
        int carries = 0;
        step(1'b0, 9, 7);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 9, 7);
            check_all("R1 R2 R3 sweep");
            if (mod_carry) begin
                carries++;
                chk("R5 wrapped residue", int'(phase_res), m_res);
            end
        end
        chk("R4 carries equal fraction", carries, 7);
    endtask

    task automatic t_change();
        step(1'b0, 3, 5);
        step(1'b1, 3, 5);
        step(1'b1, 3, 5);
        check_all("R7 before change");
        step(1'b1, 11, 13);
        check_all("R7 new value on first edge");
        chk("R7 residue uses new fraction", int'(phase_res), 7);
        chk("R7 divide uses new N", int'(div_out), 12);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 11, 13);
            check_all("R7 after change");
        end
    endtask

    task automatic t_max();
        step(1'b0, 15, 15);
        step(1'b1, 15, 15);
        chk("R9 no carry first", int'(div_out), 15);
        step(1'b1, 15, 15);
        chk("R9 N+1 at top of range", int'(div_out), 16);
        chk("R5 residue after wrap", int'(phase_res), 14);
        for (int i = 0; i < 14; i++) begin
            step(1'b1, 15, 15);
            check_all("R9 max sweep");
        end
    endtask

    task automatic t_reset_mid();
        step(1'b0, 2, 11);
        step(1'b1, 2, 11);
        step(1'b1, 2, 11);
        check_all("R6 before mid reset");
        step(1'b0, 6, 11);
        chk("R6 mid reset residue", int'(phase_res), 0);
        chk("R6 mid reset carry", int'(mod_carry), 0);
        chk("R6 mid reset divide", int'(div_out), 6);
        step(1'b1, 6, 11);
        check_all("R6 restart after reset");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_quarter();
        t_zero();
        t_sweep();
        t_change();
        t_max();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule